// File: doc/BRIEF.md
# Sparse Global Time-Base Unit

This block holds a node's copy of a global time as a 64-bit binary count: 40 bits of whole seconds above 24 bits of binary fraction, so one step of the counter is 2^-24 second. Each cycle with the tick enable high adds one step. A load port overwrites the whole value when the time is set or corrected from outside. The full value is also presented as a 16-bit short stamp, taken from the part of the count that spans a quarter second at a resolution of 2^-18 second.

Periodic activities are described by two things. One bit position of the count fixes a power-of-two period. The bits below that position give the phase within the period. Each time the counter reaches a value that matches this pattern, the trigger output pulses once.

Event capture follows a sparse time grid. Counted in ticks, the grid alternates between an active interval and a silence interval, and both lengths are configuration inputs. An event that arrives in an active interval is stamped with the integer index of that interval. An event that arrives in silence is flagged as a violation and gets no stamp.

Top module: `sparse_timebase`

## Requirements
- R1: After reset the time value is 0, the trigger is low, both event outputs are low, the grid is at the start of active interval 0, and the event index is 0.
- R2: In a cycle with tick_en high and load_en low, the time value increases by exactly 1 at the next clock edge. With both low, the value does not change.
- R3: When load_en is high, the time value at the next edge becomes load_val, whatever tick_en is.
- R4: trig_out is high only in a cycle where bit per_bit of the time is 0 and bits per_bit-1 down to 0 equal the same bits of per_phase. When per_bit is 0, the condition is simply bit 0 equal to 0.
- R5: trig_out pulses for exactly one cycle when the counter reaches a matching value through a tick or a load. If the counter then stays on that value, the trigger does not fire again.
- R6: stamp_out always equals bits [21:6] of the time value, so it wraps from 16'hFFFF to 0 when bit 22 is carried into.
- R7: A tick from the all-ones time value gives 0.
- R8: Counted in ticks from reset, the grid stays active for act_len ticks and then silent for sil_len ticks, and repeats. The interval index increases by 1 at each change from silence to active.
- R9: An event input seen at a clock edge during an active interval gives, in the next cycle, evt_valid high for one cycle and evt_index equal to the current interval index.
- R10: An event input seen at a clock edge during silence gives, in the next cycle, evt_viol high and evt_valid low.
- R11: act_len and sil_len must each be at least 1 while out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Advance the time by one step |
| load_en | input | 1 | Overwrite the time with load_val |
| load_val | input | 64 | New full time value |
| per_bit | input | 6 | Bit position that selects the period |
| per_phase | input | 64 | Phase pattern; bits below per_bit are used |
| act_len | input | 16 | Active interval length in ticks |
| sil_len | input | 16 | Silence interval length in ticks |
| evt_in | input | 1 | External event |
| time_out | output | 64 | Full time value |
| stamp_out | output | 16 | Short stamp, time bits [21:6] |
| trig_out | output | 1 | Periodic activity pulse |
| evt_valid | output | 1 | Event accepted and stamped |
| evt_index | output | 32 | Active interval index of the accepted event |
| evt_viol | output | 1 | Event rejected because it fell in silence |

## Verification
Several properties are checked on every cycle: the counter steps by one on a tick and holds without one, a load takes effect at the next edge, a trigger never lasts two cycles unless a load caused the second one, a trigger only occurs with the periodicity bit clear, an event never produces both outcomes, and the grid lengths are never zero. Only the bench scenarios can show the rest: which counter values fire the trigger for a chosen bit and phase, the grid's active and silence pattern together with the index each event receives, and where the short stamp and the full counter wrap.

// File: rtl/sparse_timebase.sv
module sparse_timebase #(
  parameter int INT_W     = 40,
  parameter int FRAC_W    = 24,
  parameter int STAMP_W   = 16,
  parameter int STAMP_LSB = 6,
  parameter int LEN_W     = 16,
  parameter int IDX_W     = 32,
  localparam int TW       = INT_W + FRAC_W,
  localparam int PB_W     = $clog2(TW)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_en,
  input  logic               load_en,
  input  logic [TW-1:0]      load_val,
  input  logic [PB_W-1:0]    per_bit,
  input  logic [TW-1:0]      per_phase,
  input  logic [LEN_W-1:0]   act_len,
  input  logic [LEN_W-1:0]   sil_len,
  input  logic               evt_in,
  output logic [TW-1:0]      time_out,
  output logic [STAMP_W-1:0] stamp_out,
  output logic               trig_out,
  output logic               evt_valid,
  output logic [IDX_W-1:0]   evt_index,
  output logic               evt_viol
);

  logic [TW-1:0]    cnt_q;
  logic             fresh_q;
  logic             act_q;
  logic [LEN_W-1:0] pos_q;
  logic [IDX_W-1:0] idx_q;

  logic [TW-1:0]    below_mask;
  logic             phase_hit;
  logic [LEN_W-1:0] cur_len;
  logic             seg_end;

  assign below_mask = (TW'(1) << per_bit) - TW'(1);
  assign phase_hit  = !cnt_q[per_bit] && (((cnt_q ^ per_phase) & below_mask) == '0);
  assign cur_len    = act_q ? act_len : sil_len;
  assign seg_end    = (pos_q == cur_len - LEN_W'(1));

  assign time_out  = cnt_q;
  assign stamp_out = cnt_q[STAMP_LSB +: STAMP_W];
  assign trig_out  = fresh_q && phase_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      fresh_q <= 1'b0;
    end else begin
      fresh_q <= load_en || tick_en;
      if (load_en)      cnt_q <= load_val;
      else if (tick_en) cnt_q <= cnt_q + TW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= 1'b1;
      pos_q <= '0;
      idx_q <= '0;
    end else if (tick_en) begin
      if (seg_end) begin
        pos_q <= '0;
        act_q <= !act_q;
        if (!act_q) idx_q <= idx_q + IDX_W'(1);
      end else begin
        pos_q <= pos_q + LEN_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_valid <= 1'b0;
      evt_viol  <= 1'b0;
      evt_index <= '0;
    end else begin
      evt_valid <= evt_in && act_q;
      evt_viol  <= evt_in && !act_q;
      if (evt_in && act_q) evt_index <= idx_q;
    end
  end

  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !load_en) |=> (time_out == $past(time_out) + TW'(1))); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !load_en) |=> $stable(time_out)); // R2
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (time_out == $past(load_val))); // R3
  AST_TRIG_BIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |-> !time_out[per_bit]); // R4
  AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |=> (!trig_out || $past(load_en))); // R5
  AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_valid && evt_viol)); // R10
  AST_VIOL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_viol |-> $past(evt_in)); // R10
  AST_LEN_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (act_len != '0) && (sil_len != '0)); // R11

endmodule

// File: tb/sparse_timebase_tb.sv
module sparse_timebase_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en, load_en, evt_in;
  logic [63:0] load_val, per_phase;
  logic [5:0]  per_bit;
  logic [15:0] act_len, sil_len;
  logic [63:0] time_out;
  logic [15:0] stamp_out;
  logic        trig_out, evt_valid, evt_viol;
  logic [31:0] evt_index;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sparse_timebase u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .load_en(load_en),
    .load_val(load_val), .per_bit(per_bit), .per_phase(per_phase),
    .act_len(act_len), .sil_len(sil_len), .evt_in(evt_in),
    .time_out(time_out), .stamp_out(stamp_out), .trig_out(trig_out),
    .evt_valid(evt_valid), .evt_index(evt_index), .evt_viol(evt_viol)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 time", time_out, 0);
    check("R1 trig", {63'd0, trig_out}, 0);
    check("R1 valid", {63'd0, evt_valid}, 0);
    check("R1 viol", {63'd0, evt_viol}, 0);
    check("R1 index", {32'd0, evt_index}, 0);
  endtask

  task automatic t_grid();
    for (int n = 0; n < 13; n++) begin
      bit act = (n % 5) < 3;
      evt_in = 1'b1;
      step();
      evt_in = 1'b0;
      check("R8 R9 valid", {63'd0, evt_valid}, {63'd0, act});
      check("R10 viol", {63'd0, evt_viol}, {63'd0, !act});
      if (act) check("R9 index", {32'd0, evt_index}, n / 5);
      tick_en = 1'b1;
      step();
      tick_en = 1'b0;
    end
    check("R9 valid one cycle", {63'd0, evt_valid}, 0);
  endtask

  task automatic t_tick_hold();
    load_en = 1'b1; load_val = 64'd100;
    step();
    load_en = 1'b0; tick_en = 1'b1;
    for (int i = 0; i < 5; i++) step();
    tick_en = 1'b0;
    check("R2 tick", time_out, 105);
    step(); step(); step();
    check("R2 hold", time_out, 105);
  endtask

  task automatic t_load();
    tick_en = 1'b1; load_en = 1'b1; load_val = 64'h0123_4567_89AB_CDEF;
    step();
    load_en = 1'b0; tick_en = 1'b0;
    check("R3 load", time_out, 64'h0123_4567_89AB_CDEF);
  endtask

  task automatic t_stamp_wrap();
    load_en = 1'b1; load_val = 64'h0000_0000_003F_FFC0;
    step();
    load_en = 1'b0;
    check("R6 stamp", {48'd0, stamp_out}, 16'hFFFF);
    tick_en = 1'b1;
    for (int i = 0; i < 64; i++) step();
    tick_en = 1'b0;
    check("R6 stamp wrap", {48'd0, stamp_out}, 0);
    check("R6 time", time_out, 64'h40_0000);
    load_en = 1'b1; load_val = '1;
    step();
    load_en = 1'b0; tick_en = 1'b1;
    step();
    tick_en = 1'b0;
    check("R7 wrap", time_out, 0);
  endtask

  task automatic t_trigger();
    int fires = 0;
    per_bit = 6'd3; per_phase = 64'hFFFF_FFFF_FFFF_FFF5;
    load_en = 1'b1; load_val = 64'd0;
    step();
    load_en = 1'b0; tick_en = 1'b1;
    for (int i = 1; i <= 32; i++) begin
      step();
      check("R4 trig pattern", {63'd0, trig_out}, {63'd0, (i % 16) == 5});
      if (trig_out) fires++;
    end
    tick_en = 1'b0;
    check("R4 fire count", fires, 2);
    load_en = 1'b1; load_val = 64'd4;
    step();
    load_en = 1'b0;
    check("R4 no fire at 4", {63'd0, trig_out}, 0);
    tick_en = 1'b1;
    step();
    tick_en = 1'b0;
    check("R5 fire at 5", {63'd0, trig_out}, 1);
    step();
    check("R5 no repeat", {63'd0, trig_out}, 0);
    step(); step();
    check("R5 still quiet", {63'd0, trig_out}, 0);
    per_bit = 6'd0;
    load_en = 1'b1; load_val = 64'd7;
    step();
    load_en = 1'b0; tick_en = 1'b1;
    step();
    tick_en = 1'b0;
    check("R4 bit0 even", {63'd0, trig_out}, 1);
  endtask

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; load_en = 1'b0; evt_in = 1'b0;
    load_val = '0; per_bit = 6'd10; per_phase = '0;
    act_len = 16'd3; sil_len = 16'd2;
    step(); step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_grid();
    t_tick_hold();
    t_load();
    t_stamp_wrap();
    t_trigger();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule